// File: doc/BRIEF.md
# ATM Receive Cell Admission Buffer

This block sits on the receive side of an ATM interworking path as the buffer for one port. Cells arrive one octet per beat, 53 octets each, with the first octet flagged by a start marker. At the start marker the block also captures a sideband user-defined-field byte and a flag that sends the cell to the processor. It keeps a fill count in whole cells. On the beat that carries the fourth header octet it decides once whether the cell is kept or dropped, and it applies that decision to the whole cell, including the three octets already received.

The drop decision compares the fill count with a threshold that all ports share. A UDF select bit chooses which priority bit is examined: the loss-priority bit in the cell header or an internal priority bit in the UDF byte. Cells bound for the processor skip this check. A cell that finds no free slot is always dropped and is counted. The block raises back-pressure early enough that the cells still in flight from upstream fit. Kept cells are read out in arrival order, one octet per beat, under a read enable.

Top module: `atm_cell_admit`

## Requirements
- R1: After reset, fill_level is 0, backpressure is 0, out_valid is 0 and all three drop counters are 0.
- R2: Kept cells leave in arrival order with all 53 octets in order. out_sop is high on the first octet and out_eop on the last. One octet advances on each cycle where rd_en and out_valid are both high.
- R3: When UDF bit 5 is 0, a cell not bound for the processor is dropped exactly when bit 0 of its fourth octet (index 3) is 1 and fill_level is greater than thresh. UDF bit 6 has no effect in this case, and each such drop adds one to clp_drop_cnt.
- R4: When UDF bit 5 is 1, a cell not bound for the processor is dropped exactly when UDF bit 6 is 1 and fill_level is greater than thresh. Octet 3 bit 0 has no effect in this case, and each such drop adds one to clpi_drop_cnt.
- R5: A fill level equal to thresh does not exceed it, so a marked cell arriving at that level is kept.
- R6: A cell with in_to_cpu high at its start is never dropped for priority, whatever its marks and the fill level.
- R7: A cell whose decision finds fill_level equal to DEPTH is dropped whatever its marks or destination. ovf_cnt counts these drops and holds at its all-ones value.
- R8: fill_level rises by one on the beat of the fourth octet of a kept cell and falls by one when the last octet of a cell is read. It never exceeds DEPTH.
- R9: backpressure is high exactly when fill_level is at least DEPTH minus INFLIGHT, which leaves INFLIGHT free slots for cells already in transit.
- R10: A dropped cell leaves no trace: fill_level, the stored cells and the output stream are the same as if it had never arrived.
- R11: Beats with in_valid low inside a cell are skipped. The decision uses the fill level on the cycle the fourth octet is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input octet valid |
| in_sop | input | 1 | Input octet is the first of a cell |
| in_data | input | 8 | Input octet |
| in_udf | input | 8 | Sideband UDF byte, taken at start of cell |
| in_to_cpu | input | 1 | Cell goes to the processor, taken at start of cell |
| thresh | input | $clog2(DEPTH+1) | Shared discard threshold in cells |
| rd_en | input | 1 | Read enable for the output octet |
| out_valid | output | 1 | At least one complete kept cell is stored |
| out_data | output | 8 | Output octet |
| out_sop | output | 1 | Output octet is the first of its cell |
| out_eop | output | 1 | Output octet is the last of its cell |
| fill_level | output | $clog2(DEPTH+1) | Cells reserved or stored |
| backpressure | output | 1 | Upstream should stop sending cells |
| ovf_cnt | output | CNT_W | Saturating count of drops on a full buffer |
| clp_drop_cnt | output | CNT_W | Saturating count of drops on the header priority bit |
| clpi_drop_cnt | output | CNT_W | Saturating count of drops on the internal priority bit |

## Verification
The bench sends cells whose unselected priority bit is set, to catch a design that ORs the two bits or ignores the select bit. Such a design would drop cells that must be kept. It places a marked cell at a fill level exactly equal to the threshold, where an off-by-one compare would drop it, and sends processor-bound cells marked for drop, which a missing bypass would lose. It fills the buffer completely with idle gaps inside a cell. Then it sends a few hundred cells into the full buffer. A design that let a dropped cell's early octets leak into a slot, or whose overflow counter wrapped, would corrupt the read-back stream or show a small ovf_cnt.

// File: rtl/atm_cell_admit.sv
module atm_cell_admit #(
  parameter int DEPTH    = 16,
  parameter int INFLIGHT = 8,
  parameter int CNT_W    = 8,
  localparam int FW      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  input  logic [7:0]       in_udf,
  input  logic             in_to_cpu,
  input  logic [FW-1:0]    thresh,
  input  logic             rd_en,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic [FW-1:0]    fill_level,
  output logic             backpressure,
  output logic [CNT_W-1:0] ovf_cnt,
  output logic [CNT_W-1:0] clp_drop_cnt,
  output logic [CNT_W-1:0] clpi_drop_cnt
);
  localparam int CELL   = 53;
  localparam int PW     = $clog2(DEPTH);
  localparam int AW     = $clog2(DEPTH * CELL);
  localparam int BP_LVL = DEPTH - INFLIGHT;

  logic [7:0]    mem [DEPTH*CELL];
  logic [5:0]    bcnt, rbyte;
  logic          in_cell, keep, enb_q, clpi_q, cpu_q;
  logic [7:0]    h0, h1, h2;
  logic [PW-1:0] wcell, rcell;
  logic [FW-1:0] fill, done_cnt;
  logic          unused_udf;

  assign unused_udf = ^{in_udf[7], in_udf[4:0]};

  wire beat      = in_valid && in_cell && !in_sop;
  wire decide    = beat && bcnt == 6'd3;
  wire full      = fill == FW'(DEPTH);
  wire over      = fill > thresh;
  wire prio      = enb_q ? clpi_q : in_data[0];
  wire drop_ovf  = decide && full;
  wire drop_prio = decide && !full && !cpu_q && over && prio;
  wire accept    = decide && !drop_ovf && !drop_prio;
  wire last      = beat && bcnt == 6'd52 && keep;
  wire pop       = rd_en && out_valid && rbyte == 6'd52;

  wire [AW-1:0] wbase = AW'(wcell) * AW'(CELL);
  wire [AW-1:0] rbase = AW'(rcell) * AW'(CELL);

  assign out_valid    = done_cnt != '0;
  assign out_data     = mem[rbase + AW'(rbyte)];
  assign out_sop      = rbyte == 6'd0;
  assign out_eop      = rbyte == 6'd52;
  assign fill_level   = fill;
  assign backpressure = fill >= FW'(BP_LVL);

  always_ff @(posedge clk) begin
    if (accept) begin
      mem[wbase]           <= h0;
      mem[wbase + AW'(1)]  <= h1;
      mem[wbase + AW'(2)]  <= h2;
      mem[wbase + AW'(3)]  <= in_data;
    end else if (beat && keep && bcnt > 6'd3) begin
      mem[wbase + AW'(bcnt)] <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cell <= 1'b0;
      keep    <= 1'b0;
      bcnt    <= '0;
      h0      <= '0;
      h1      <= '0;
      h2      <= '0;
      enb_q   <= 1'b0;
      clpi_q  <= 1'b0;
      cpu_q   <= 1'b0;
      wcell   <= '0;
    end else if (in_valid && in_sop) begin
      in_cell <= 1'b1;
      keep    <= 1'b0;
      bcnt    <= 6'd1;
      h0      <= in_data;
      enb_q   <= in_udf[5];
      clpi_q  <= in_udf[6];
      cpu_q   <= in_to_cpu;
    end else if (beat) begin
      bcnt <= bcnt + 6'd1;
      if (bcnt == 6'd1) h1 <= in_data;
      if (bcnt == 6'd2) h2 <= in_data;
      if (accept) keep <= 1'b1;
      if (bcnt == 6'd52) begin
        in_cell <= 1'b0;
        keep    <= 1'b0;
        if (keep) wcell <= (wcell == PW'(DEPTH - 1)) ? '0 : wcell + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill          <= '0;
      done_cnt      <= '0;
      rbyte         <= '0;
      rcell         <= '0;
      ovf_cnt       <= '0;
      clp_drop_cnt  <= '0;
      clpi_drop_cnt <= '0;
    end else begin
      fill     <= fill + FW'(accept) - FW'(pop);
      done_cnt <= done_cnt + FW'(last) - FW'(pop);
      if (rd_en && out_valid) rbyte <= (rbyte == 6'd52) ? '0 : rbyte + 6'd1;
      if (pop) rcell <= (rcell == PW'(DEPTH - 1)) ? '0 : rcell + PW'(1);
      if (drop_ovf && ovf_cnt != '1) ovf_cnt <= ovf_cnt + CNT_W'(1);
      if (drop_prio && !enb_q && clp_drop_cnt != '1) clp_drop_cnt <= clp_drop_cnt + CNT_W'(1);
      if (drop_prio && enb_q && clpi_drop_cnt != '1) clpi_drop_cnt <= clpi_drop_cnt + CNT_W'(1);
    end
  end

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH) && done_cnt <= fill);

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && full) |=> fill == $past(fill) - FW'($past(pop)));

  assert_ovf_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && full && ovf_cnt != '1) |=> ovf_cnt == $past(ovf_cnt) + CNT_W'(1));

  assert_cpu_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && cpu_q && !full) |=> keep);

  assert_at_thresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !full && fill <= thresh) |=> keep);

  assert_bp_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backpressure) |-> fill == FW'(BP_LVL));

  assert_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && out_valid && out_eop) |=> out_sop);
endmodule

// File: tb/tb_atm_cell_admit.sv
module tb_atm_cell_admit;
  localparam int DEPTH = 16;
  localparam int INFL  = 8;
  localparam int FW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_to_cpu = 1'b0, rd_en = 1'b0;
  logic [7:0] in_data = '0, in_udf = '0;
  logic [FW-1:0] thresh = '0;
  logic out_valid, out_sop, out_eop, backpressure;
  logic [7:0] out_data, ovf_cnt, clp_drop_cnt, clpi_drop_cnt;
  logic [FW-1:0] fill_level;

  atm_cell_admit #(.DEPTH(DEPTH), .INFLIGHT(INFL), .CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .in_udf(in_udf), .in_to_cpu(in_to_cpu), .thresh(thresh), .rd_en(rd_en),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .fill_level(fill_level), .backpressure(backpressure), .ovf_cnt(ovf_cnt),
    .clp_drop_cnt(clp_drop_cnt), .clpi_drop_cnt(clpi_drop_cnt));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int fill_m = 0, ovf_m = 0, clp_m = 0, clpi_m = 0;
  bit finished = 1'b0;
  logic [9:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] cb(input logic [7:0] seed, input int i, input bit clp);
    return (i == 3) ? {seed[6:0], clp} : seed + 8'(i * 13);
  endfunction

  task automatic send_cell(input logic [7:0] udf, input bit cpu, input bit clp,
                           input logic [7:0] seed, input bit gaps);
    bit enb, clpi, kept;
    enb = udf[5];
    clpi = udf[6];
    kept = 1'b0;
    if (fill_m == DEPTH) begin
      if (ovf_m < 255) ovf_m++;
    end else if (!cpu && fill_m > int'(thresh) && (enb ? clpi : clp)) begin
      if (enb) begin if (clpi_m < 255) clpi_m++; end
      else begin if (clp_m < 255) clp_m++; end
    end else begin
      kept = 1'b1;
      fill_m++;
    end
    for (int i = 0; i < 53; i++) begin
      if (gaps && (i == 2 || i == 3 || i == 30)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data = 8'hEE;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sop = (i == 0);
      in_data = cb(seed, i, clp);
      in_udf = (i == 0) ? udf : 8'h00;
      in_to_cpu = (i == 0) ? cpu : 1'b0;
      if (kept) exp_q.push_back({i == 0, i == 52, cb(seed, i, clp)});
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sop = 1'b0;
    chk(fill_level == FW'(fill_m), "R8/R10", "fill_level", fill_level, fill_m);
    chk(backpressure == (fill_m >= DEPTH - INFL), "R9", "backpressure", backpressure, fill_m >= DEPTH - INFL);
    chk(ovf_cnt == 8'(ovf_m), "R7", "ovf_cnt", ovf_cnt, ovf_m);
    chk(clp_drop_cnt == 8'(clp_m), "R3", "clp_drop_cnt", clp_drop_cnt, clp_m);
    chk(clpi_drop_cnt == 8'(clpi_m), "R4", "clpi_drop_cnt", clpi_drop_cnt, clpi_m);
  endtask

  task automatic drain(input int n);
    repeat (n * 53) begin
      @(negedge clk);
      rd_en = 1'b1;
    end
    @(negedge clk);
    rd_en = 1'b0;
    fill_m -= n;
    @(negedge clk);
    chk(fill_level == FW'(fill_m), "R8", "fill after drain", fill_level, fill_m);
    chk(out_valid == (fill_m != 0), "R2", "out_valid after drain", out_valid, fill_m != 0);
    if (fill_m == 0) chk(exp_q.size() == 0, "R2/R10", "expected octets left", exp_q.size(), 0);
  endtask

  initial begin : monitor
    logic [9:0] e;
    forever begin
      @(negedge clk);
      #2;
      if (rd_en && out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R10", "unexpected octet", out_data, -1);
        end else begin
          e = exp_q.pop_front();
          chk({out_sop, out_eop, out_data} == e, "R2", "octet {sop,eop,data}",
              {out_sop, out_eop, out_data}, e);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      chk(1'b0, "watchdog", "run hung", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fill_level == '0, "R1", "fill_level", fill_level, 0);
    chk(backpressure == 1'b0, "R1", "backpressure", backpressure, 0);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(ovf_cnt == 0 && clp_drop_cnt == 0 && clpi_drop_cnt == 0, "R1", "counters", ovf_cnt, 0);

    thresh = FW'(4);
    for (int k = 0; k < 5; k++) send_cell(8'h00, 1'b0, 1'b0, 8'(16 * k + 1), 1'b0);
    send_cell(8'h00, 1'b0, 1'b1, 8'h51, 1'b0);  // R3 drop: header bit set, fill 5 > 4
    send_cell(8'h40, 1'b0, 1'b0, 8'h52, 1'b0);  // R3 internal bit ignored: kept
    send_cell(8'h60, 1'b0, 1'b0, 8'h53, 1'b0);  // R4 drop: internal bit selected and set
    send_cell(8'h20, 1'b0, 1'b1, 8'h54, 1'b0);  // R4 header bit ignored: kept, fill 7
    send_cell(8'h00, 1'b1, 1'b1, 8'h55, 1'b0);  // R6 processor cell kept, fill 8, R9 bp on
    send_cell(8'h60, 1'b1, 1'b1, 8'h56, 1'b0);  // R6 again with internal select
    drain(9);

    thresh = FW'(2);
    send_cell(8'h00, 1'b0, 1'b0, 8'h61, 1'b0);
    send_cell(8'h00, 1'b0, 1'b0, 8'h62, 1'b0);
    send_cell(8'h00, 1'b0, 1'b1, 8'h63, 1'b0);  // R5 fill == thresh: kept
    send_cell(8'h00, 1'b0, 1'b1, 8'h64, 1'b0);  // R3 fill 3 > 2: dropped
    drain(3);

    for (int k = 0; k < DEPTH; k++) send_cell(8'h60, 1'b1, 1'b1, 8'(8 * k + 3), k == 5); // R11 gaps
    send_cell(8'h00, 1'b1, 1'b0, 8'h77, 1'b1);  // R7 full: dropped even for processor
    drain(4);
    send_cell(8'h00, 1'b0, 1'b0, 8'h81, 1'b0);
    for (int k = 0; k < 3; k++) send_cell(8'h00, 1'b0, 1'b0, 8'(k + 90), 1'b0);
    for (int k = 0; k < 260; k++) send_cell(8'h00, 1'b0, 1'b0, 8'(k), 1'b0); // R7 saturation
    chk(ovf_cnt == 8'hFF, "R7", "ovf_cnt saturated", ovf_cnt, 255);
    drain(DEPTH);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule